// File: doc/BRIEF.md
# Dual-channel serial DAC register controller

This block is the digital front end of a two-channel 8-bit converter. A host writes 16-bit command words over a three-wire serial port: an active-low frame-select line, a serial clock and a data line. The block oversamples those three wires with its own system clock, which must run at least four times faster than the serial clock. It assembles each frame and, when frame-select returns high, decodes the upper control byte and commits the lower data byte.

Each channel has two registers. An input register holds a staged value. An output register is the value presented to the converter. The control byte chooses among four actions: loading both outputs at once, staging into one input register, moving a staged value to its output, or writing one output directly. A software-load bit stages one channel and refreshes both outputs in the same update. Every accepted frame also sets the two per-channel power-down flags and the reference-select flag. A one-cycle pulse marks each executed command. A frame whose bit count is not exactly sixteen is dropped.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After reset, both outputs are 0, the power-down and reference flags are 0, and the command pulse is low.
- R2: While fs_n is low, each rising sck edge shifts sdi into the frame most-significant bit first. Frame layout: bit 15 is ref_ext (0 internal, 1 external), bit 14 is unused, bit 13 is the software-load bit, bit 12 is pd_b, bit 11 is pd_a, bit 10 is the channel select (0 = A, 1 = B), bits 9:8 are the mode, and bits 7:0 are data.
- R3: A complete frame is committed only on the rising edge of fs_n. Its results appear on the third rising system clock edge, counting the edge that first samples fs_n high. cmd_pulse is high for exactly that one cycle.
- R4: With load bit 0 and mode 00, both output registers take the data byte, whatever the channel bit is. The input registers are unchanged.
- R5: With load bit 0 and mode 01, the selected channel's input register takes the data byte. Neither output changes.
- R6: With load bit 0 and mode 10, the selected channel's output takes the value of that channel's input register.
- R7: With load bit 0 and mode 11, the selected channel's output takes the data byte. Its input register is unchanged.
- R8: With load bit 1, the selected input register takes the data byte, and in the same update both outputs take their channel's (new) input value. The mode bits are ignored.
- R9: Every accepted frame sets pd_a, pd_b and ref_ext from its bits. Power-down does not alter any data register.
- R10: If fs_n rises after any number of bits other than 16, nothing changes and no pulse is produced.
- R11: A frame sent as two 8-bit bursts, with fs_n held low between them, behaves as one 16-bit frame.
- R12: sck edges while fs_n is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fs_n | input | 1 | Active-low frame select |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data |
| out_a | output | 8 | Channel A output register |
| out_b | output | 8 | Channel B output register |
| pd_a | output | 1 | Channel A power-down flag |
| pd_b | output | 1 | Channel B power-down flag |
| ref_ext | output | 1 | External reference selected |
| cmd_pulse | output | 1 | One-cycle pulse per executed command |

## Verification
Each output and flag register changes on the third system edge after fs_n is first sampled high: two synchroniser edges, then the commit edge. cmd_pulse is high only in the cycle that follows. The bench raises fs_n at a falling clock edge and waits exactly three rising edges before it updates its own expected state, and it compares every output on every falling edge. A value that arrives one cycle early or late therefore fails. Input registers are observed only through later transfer frames, and dropped frames are checked by confirming that no output or pulse moves.

// File: rtl/dac_ctrl_pkg.sv
`timescale 1ns/1ps
package dac_ctrl_pkg;
  parameter int DATA_W  = 8;
  parameter int CTRL_W  = 8;
  parameter int FRAME_W = CTRL_W + DATA_W;
  parameter int NUM_CH  = 2;

  typedef enum logic [1:0] {
    M_BOTH_DIRECT = 2'b00,
    M_LOAD_IN     = 2'b01,
    M_XFER        = 2'b10,
    M_OUT_DIRECT  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    SRC_KEEP, SRC_DATA, SRC_INPUT
  } out_src_e;

  typedef struct packed {
    logic              ref_ext;
    logic              spare;
    logic              swload;
    logic              pd_b;
    logic              pd_a;
    logic              sel_b;
    mode_e             mode;
    logic [DATA_W-1:0] data;
  } frame_t;

  function automatic logic in_load(frame_t f, logic sel);
    return sel && (f.swload || f.mode == M_LOAD_IN);
  endfunction

  function automatic out_src_e out_source(frame_t f, logic sel);
    if (f.swload) return sel ? SRC_DATA : SRC_INPUT;
    case (f.mode)
      M_BOTH_DIRECT: return SRC_DATA;
      M_XFER:        return sel ? SRC_INPUT : SRC_KEEP;
      M_OUT_DIRECT:  return sel ? SRC_DATA : SRC_KEEP;
      default:       return SRC_KEEP;
    endcase
  endfunction
endpackage

// File: rtl/dac_serial_sync.sv
`timescale 1ns/1ps
module dac_serial_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic fs_n,
  input  logic sdi,
  output logic sck_rise,
  output logic fs_rise,
  output logic fs_low,
  output logic sdi_s
);
  logic [STAGES-1:0] sck_p, fs_p, sd_p;
  logic sck_q, fs_q;
  logic sck_s, fs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      fs_p  <= '1;
      sd_p  <= '0;
      sck_q <= 1'b0;
      fs_q  <= 1'b1;
    end else begin
      sck_p <= {sck_p[STAGES-2:0], sck};
      fs_p  <= {fs_p[STAGES-2:0], fs_n};
      sd_p  <= {sd_p[STAGES-2:0], sdi};
      sck_q <= sck_s;
      fs_q  <= fs_s;
    end
  end

  assign sck_s    = sck_p[STAGES-1];
  assign fs_s     = fs_p[STAGES-1];
  assign sck_rise = sck_s & ~sck_q;
  assign fs_rise  = fs_s & ~fs_q;
  assign fs_low   = ~fs_s;
  assign sdi_s    = sd_p[STAGES-1];
endmodule

// File: rtl/dac_frame_shifter.sv
`timescale 1ns/1ps
module dac_frame_shifter
  import dac_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck_rise,
  input  logic               fs_rise,
  input  logic               fs_low,
  input  logic               sdi_s,
  output logic               frame_go,
  output logic [FRAME_W-1:0] frame_word
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (!fs_low) begin
      cnt <= '0;
    end else if (sck_rise) begin
      shreg <= {shreg[FRAME_W-2:0], sdi_s};
      if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
    end
  end

  assign frame_go   = fs_rise && (cnt == CNT_FULL);
  assign frame_word = shreg;

  // R12: no shifting or counting while the frame is not selected
  assert_idle_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_low |=> (cnt == '0) && $stable(shreg));
endmodule

// File: rtl/dac_cmd_exec.sv
`timescale 1ns/1ps
module dac_cmd_exec
  import dac_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [FRAME_W-1:0] frame_word,
  output logic [DATA_W-1:0]  out_a,
  output logic [DATA_W-1:0]  out_b,
  output logic               pd_a,
  output logic               pd_b,
  output logic               ref_ext,
  output logic               cmd_pulse
);
  frame_t f;
  logic [DATA_W-1:0] in_vec  [NUM_CH];
  logic [DATA_W-1:0] out_vec [NUM_CH];
  logic pd_a_q, pd_b_q, ref_q, pulse_q;

  assign f = frame_t'(frame_word);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic CH_ID = 1'(ch);
    logic [DATA_W-1:0] in_q, out_q;
    logic     sel;
    out_src_e src;
    assign sel = (f.sel_b == CH_ID);
    assign src = out_source(f, sel);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q  <= '0;
        out_q <= '0;
      end else if (go) begin
        if (in_load(f, sel)) in_q <= f.data;
        case (src)
          SRC_DATA:  out_q <= f.data;
          SRC_INPUT: out_q <= in_q;
          default:   ;
        endcase
      end
    end
    assign in_vec[ch]  = in_q;
    assign out_vec[ch] = out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_a_q  <= 1'b0;
      pd_b_q  <= 1'b0;
      ref_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= go;
      if (go) begin
        pd_a_q <= f.pd_a;
        pd_b_q <= f.pd_b;
        ref_q  <= f.ref_ext;
      end
    end
  end

  assign out_a     = out_vec[0];
  assign out_b     = out_vec[1];
  assign pd_a      = pd_a_q;
  assign pd_b      = pd_b_q;
  assign ref_ext   = ref_q;
  assign cmd_pulse = pulse_q;

  // R3: a command pulse never lasts more than one cycle
  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pulse |=> !cmd_pulse);
  // R10: without a commit no data register moves
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> ($stable(out_vec[0]) && $stable(out_vec[1]) &&
             $stable(in_vec[0]) && $stable(in_vec[1])));
  // R9: flags move only on an accepted frame
  assert_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable({pd_a_q, pd_b_q, ref_q}));
  // R8: after a software load every output matches its input register
  assert_swload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && f.swload) |=> (out_vec[0] == in_vec[0]) && (out_vec[1] == in_vec[1]));
endmodule

// File: rtl/dual_dac_ctrl.sv
`timescale 1ns/1ps
module dual_dac_ctrl
  import dac_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_n,
  input  logic              sck,
  input  logic              sdi,
  output logic [DATA_W-1:0] out_a,
  output logic [DATA_W-1:0] out_b,
  output logic              pd_a,
  output logic              pd_b,
  output logic              ref_ext,
  output logic              cmd_pulse
);
  logic sck_rise, fs_rise, fs_low, sdi_s;
  logic frame_go;
  logic [FRAME_W-1:0] frame_word;

  dac_serial_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .fs_n(fs_n), .sdi(sdi),
    .sck_rise(sck_rise), .fs_rise(fs_rise), .fs_low(fs_low), .sdi_s(sdi_s)
  );

  dac_frame_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .fs_rise(fs_rise),
    .fs_low(fs_low), .sdi_s(sdi_s), .frame_go(frame_go), .frame_word(frame_word)
  );

  dac_cmd_exec u_exec (
    .clk(clk), .rst_n(rst_n), .go(frame_go), .frame_word(frame_word),
    .out_a(out_a), .out_b(out_b), .pd_a(pd_a), .pd_b(pd_b),
    .ref_ext(ref_ext), .cmd_pulse(cmd_pulse)
  );
endmodule

// File: tb/dual_dac_ctrl_bench.sv
`timescale 1ns/1ps
module dual_dac_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [7:0] out_a, out_b;
  logic pd_a, pd_b, ref_ext, cmd_pulse;

  int total = 0, bad = 0;
  bit run_chk = 0;
  bit done = 0;
  string cur_req = "R1";

  int exp_in  [2];
  int exp_out [2];
  int exp_pda = 0, exp_pdb = 0, exp_ref = 0, exp_pulse = 0;

  always #2.5 clk = ~clk;

  dual_dac_ctrl u_dual_dac_ctrl (
    .clk(clk), .rst_n(rst_n), .fs_n(fs_n), .sck(sck), .sdi(sdi),
    .out_a(out_a), .out_b(out_b), .pd_a(pd_a), .pd_b(pd_b),
    .ref_ext(ref_ext), .cmd_pulse(cmd_pulse)
  );

  task automatic chk(string req, string what, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run_chk) begin
      chk(cur_req, "out_a", out_a, exp_out[0]);
      chk(cur_req, "out_b", out_b, exp_out[1]);
      chk(cur_req, "pd_a", pd_a, exp_pda);
      chk(cur_req, "pd_b", pd_b, exp_pdb);
      chk(cur_req, "ref_ext", ref_ext, exp_ref);
      chk("R3", "cmd_pulse", cmd_pulse, exp_pulse);
    end
  end

  function automatic logic [15:0] mk(int rf, int ld, int pdb, int pda, int sel, int mode, int data);
    return 16'((rf << 15) | (ld << 13) | (pdb << 12) | (pda << 11) |
               (sel << 10) | (mode << 8) | (data & 255));
  endfunction

  task automatic model(logic [15:0] w);
    int s, d;
    s = w[10] ? 1 : 0;
    d = int'(w[7:0]);
    if (w[13]) begin
      exp_in[s] = d;
      exp_out[0] = exp_in[0];
      exp_out[1] = exp_in[1];
    end else begin
      case (int'(w[9:8]))
        0: begin exp_out[0] = d; exp_out[1] = d; end
        1: exp_in[s] = d;
        2: exp_out[s] = exp_in[s];
        default: exp_out[s] = d;
      endcase
    end
    exp_pda = int'(w[11]);
    exp_pdb = int'(w[12]);
    exp_ref = int'(w[15]);
  endtask

  task automatic one_bit(logic b);
    @(negedge clk); sdi = b; sck = 1'b0;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  // sends the n low bits of w, MSB first; optional pause after the first half
  task automatic frame(string req, logic [31:0] w, int n, bit split);
    cur_req = req;
    @(negedge clk); fs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      one_bit(w[i]);
      if (split && i == n / 2) repeat (12) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    fs_n = 1'b1;
    repeat (3) @(posedge clk);
    if (n == 16) begin
      model(w[15:0]);
      exp_pulse = 1;
    end
    @(posedge clk);
    exp_pulse = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    exp_in[0] = 0; exp_in[1] = 0; exp_out[0] = 0; exp_out[1] = 0;
    @(posedge clk); #1 run_chk = 1;
    repeat (3) @(negedge clk);
    chk("R1", "reset out_a", out_a, 0);
    chk("R1", "reset pulse", cmd_pulse, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    frame("R5", {16'h0, mk(0,0,0,0,0,1,8'h5A)}, 16, 0);
    chk("R5", "out_a after stage", out_a, 0);
    frame("R6", {16'h0, mk(0,0,0,0,0,2,0)}, 16, 0);
    chk("R6", "out_a after transfer", out_a, 8'h5A);
    frame("R7", {16'h0, mk(0,0,0,0,1,3,8'hC3)}, 16, 0);
    chk("R7", "out_b direct", out_b, 8'hC3);
    frame("R7", {16'h0, mk(0,0,0,0,1,2,0)}, 16, 0);
    chk("R7", "in_b untouched", out_b, 0);
    frame("R4", {16'h0, mk(0,0,0,0,1,0,8'h77)}, 16, 0);
    chk("R4", "both out_a", out_a, 8'h77);
    chk("R4", "both out_b", out_b, 8'h77);
    frame("R8", {16'h0, mk(0,0,0,0,1,1,8'h11)}, 16, 0);
    frame("R8", {16'h0, mk(0,1,0,0,0,3,8'h22)}, 16, 0);
    chk("R8", "swload out_a", out_a, 8'h22);
    chk("R8", "swload out_b", out_b, 8'h11);
    frame("R9", {16'h0, mk(1,0,0,1,0,1,8'h99)}, 16, 0);
    chk("R9", "pd_a set", pd_a, 1);
    chk("R9", "ref_ext set", ref_ext, 1);
    chk("R9", "out_a kept", out_a, 8'h22);
    frame("R9", {16'h0, mk(0,0,1,1,1,2,0)}, 16, 0);
    chk("R9", "pd_b set", pd_b, 1);
    frame("R9", {16'h0, mk(0,0,0,0,0,2,0)}, 16, 0);
    chk("R9", "staged value survives", out_a, 8'h99);
    frame("R2", {16'h0, mk(0,0,0,0,0,3,8'h01)}, 16, 0);
    chk("R2", "msb first", out_a, 8'h01);
    frame("R10", {24'h0, 8'h80}, 8, 0);
    frame("R10", {15'h0, 1'b0, mk(0,0,0,0,0,0,8'hEE)}, 17, 0);
    frame("R10", {17'h0, 15'h00FF}, 15, 0);
    chk("R10", "short/long dropped out_a", out_a, 8'h01);
    chk("R10", "short/long dropped out_b", out_b, 8'h11);
    frame("R11", {16'h0, mk(0,0,0,0,0,0,8'h3C)}, 16, 1);
    chk("R11", "split frame out_b", out_b, 8'h3C);
    cur_req = "R12";
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); sdi = k[0]; sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
      repeat (4) @(negedge clk);
    end
    chk("R12", "idle clocks ignored", out_a, 8'h3C);
    frame("R12", {16'h0, mk(0,0,0,0,1,3,8'hE1)}, 16, 0);
    chk("R12", "frame after idle clocks", out_b, 8'hE1);
    chk("R12", "other channel kept", out_a, 8'h3C);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule